// File: doc/BRIEF.md
# Multiplexed Segment LCD Waveform Sequencer

This block produces the digital drive schedule for a multiplexed segment LCD with up to 40 frontplanes and 4 backplanes. A free-running prescaler divides the source clock into a phase tick. A phase counter walks the backplanes one at a time, and a polarity bit flips at the end of every frame so that each segment sees zero average drive. The outputs are 2-bit voltage-level indices for every backplane and frontplane. An external bias ladder and pad drivers turn these indices into voltages.

Segment data sits in a 4-row store with one bit per frontplane per backplane. A host reads and writes the store one row at a time. The global enable only controls the waveform, so the store works as ordinary RAM whether the display runs or not. Mode, divider and per-frontplane enables are plain inputs. A mode change is held back until the running frame ends.

Top module: `segmux_lcd`

## Requirements
- R1: The 3-bit mode code selects the backplane count and top level T: 0 gives 1 backplane with T=1, 1 gives 2 with T=2, 2 gives 2 with T=3, 3 gives 3 with T=3, and 4 gives 4 with T=3. Codes 5 to 7 behave as code 0. Level codes are 2-bit indices, where 0 is ground and T is the highest level used.
- R2: Each backplane phase lasts 2^(DIV_BASE_LOG2 + clk_div_i) source cycles. The default DIV_BASE_LOG2 of 16 gives 65536 or 131072 cycles for divider codes 0 and 1.
- R3: A frame has one phase per used backplane, and backplane j is active in phase j in ascending order. Under polarity 0 the active backplane drives T and the other used backplanes drive 1. Backplanes numbered at or above the count drive 0. The first phase after enable appears 2 clocks after the first edge that samples the enable high.
- R4: Polarity starts at 0 when the block is enabled and inverts at every frame boundary. Under polarity 1 every used backplane and enabled frontplane level v becomes T−v.
- R5: Under polarity 0, an enabled frontplane in phase j drives 0 when bit i of store row j is 1. It drives T when that bit is 0, or 2 when T is 3.
- R6: A frontplane drives 0 unless both the global enable and its own enable are set. While the block runs, a change to a frontplane enable reaches that frontplane's output after one clock.
- R7: While the global enable is low, all outputs are 0 within 2 clocks and the prescaler, phase and polarity are held at zero. Enabling again restarts at phase 0 with polarity 0.
- R8: A new mode code is taken only at the end of a frame, so a frame never mixes two modes. While disabled, the mode code is taken directly.
- R9: A host write stores host_wdata_i into row host_addr_i, where the row is the backplane index and bit i is frontplane i. host_rdata_o shows the addressed row one clock later. Storing and reading do not depend on the enable, and toggling the enable leaves the contents unchanged.
- R10: After reset all level outputs are 0, and the prescaler, phase and polarity are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_en_i | input | 1 | Global waveform enable |
| mode_i | input | 3 | Duty/bias mode code |
| clk_div_i | input | 2 | Prescaler exponent offset |
| fp_en_i | input | NUM_FP | Per-frontplane enable |
| host_we_i | input | 1 | Store row write strobe |
| host_addr_i | input | 2 | Store row (backplane index) |
| host_wdata_i | input | NUM_FP | Row write data |
| host_rdata_o | output | NUM_FP | Registered row read data |
| bp_lvl_o | output | 8 | Backplane level codes, 2 bits each, backplane j at [2j+1:2j] |
| fp_lvl_o | output | 2*NUM_FP | Frontplane level codes, frontplane i at [2i+1:2i] |

## Verification
The assertions check the sequencing invariants on every cycle. The phase always stays below the active backplane count, the mode holds steady mid-frame, and polarity flips only as the phase wraps to zero. While disabled, the counters stay cleared and all outputs are ground. A disabled frontplane reads ground one clock later. The actual level values can only be shown by the bench scenarios. These cover the mirrored codes of each mode, the order of the backplanes, the length of the divider periods, and the exact frame where a mode change lands. The same holds for the store contents surviving an enable toggle.

// File: rtl/segmux_pkg.sv
package segmux_pkg;

  localparam int BP_MAX = 4;
  localparam int PH_W   = 2;
  localparam int LVL_W  = 2;
  localparam int DUTY_W = PH_W + 1;

  typedef enum logic [2:0] {
    MODE_STATIC = 3'd0,
    MODE_D2_B2  = 3'd1,
    MODE_D2_B3  = 3'd2,
    MODE_D3_B3  = 3'd3,
    MODE_D4_B3  = 3'd4
  } mux_mode_e;

  function automatic mux_mode_e norm_mode(input logic [2:0] code);
    if (code > 3'd4) return MODE_STATIC;
    return mux_mode_e'(code);
  endfunction

  function automatic logic [DUTY_W-1:0] duty_of(input mux_mode_e m);
    case (m)
      MODE_D2_B2, MODE_D2_B3: return DUTY_W'(2);
      MODE_D3_B3:             return DUTY_W'(3);
      MODE_D4_B3:             return DUTY_W'(4);
      default:                return DUTY_W'(1);
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] top_of(input mux_mode_e m);
    case (m)
      MODE_STATIC: return LVL_W'(1);
      MODE_D2_B2:  return LVL_W'(2);
      default:     return LVL_W'(3);
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] mirror(input logic [LVL_W-1:0] lvl,
                                               input logic [LVL_W-1:0] top,
                                               input logic             pol);
    return pol ? (top - lvl) : lvl;
  endfunction

endpackage

// File: rtl/segmux_timing.sv
module segmux_timing
  import segmux_pkg::*;
#(
  parameter int DIV_BASE_LOG2 = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_i,
  input  logic [2:0]      mode_i,
  input  logic [1:0]      div_sel_i,
  output logic [PH_W-1:0] phase_o,
  output logic            pol_o,
  output mux_mode_e       mode_o
);

  localparam int CNT_W = DIV_BASE_LOG2 + 4;

  logic [CNT_W-1:0] presc_q;
  logic [CNT_W-1:0] div_max;
  logic [PH_W-1:0]  phase_q;
  logic             pol_q;
  mux_mode_e        mode_q;
  logic             frame_last;

  always_comb begin
    div_max    = (CNT_W'(1) << (DIV_BASE_LOG2 + int'(div_sel_i))) - CNT_W'(1);
    frame_last = ({1'b0, phase_q} == (duty_of(mode_q) - DUTY_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      phase_q <= '0;
      pol_q   <= 1'b0;
      mode_q  <= MODE_STATIC;
    end else if (!run_i) begin
      presc_q <= '0;
      phase_q <= '0;
      pol_q   <= 1'b0;
      mode_q  <= norm_mode(mode_i);
    end else if (presc_q >= div_max) begin
      presc_q <= '0;
      if (frame_last) begin
        phase_q <= '0;
        pol_q   <= ~pol_q;
        mode_q  <= norm_mode(mode_i);
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end else begin
      presc_q <= presc_q + CNT_W'(1);
    end
  end

  assign phase_o = phase_q;
  assign pol_o   = pol_q;
  assign mode_o  = mode_q;

  p_phase_range_r3: assert property (@(posedge clk) disable iff (rst)
    {1'b0, phase_q} < duty_of(mode_q));

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run_i && $past(run_i) && phase_q != '0) |-> $stable(mode_q));

  p_pol_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(pol_q) && run_i) |-> (phase_q == '0));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (presc_q == '0 && phase_q == '0 && !pol_q));

endmodule

// File: rtl/segmux_store.sv
module segmux_store
  import segmux_pkg::*;
#(
  parameter int NUM_FP = 40
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [PH_W-1:0]   addr_i,
  input  logic [NUM_FP-1:0] wdata_i,
  output logic [NUM_FP-1:0] rdata_o,
  input  logic [PH_W-1:0]   disp_idx_i,
  output logic [NUM_FP-1:0] disp_row_o
);

  logic [NUM_FP-1:0] mem_q [BP_MAX];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o    <= mem_q[addr_i];
    disp_row_o <= mem_q[disp_idx_i];
  end

endmodule

// File: rtl/segmux_levels.sv
module segmux_levels
  import segmux_pkg::*;
#(
  parameter int NUM_FP = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run_i,
  input  logic [PH_W-1:0]          phase_i,
  input  logic                     pol_i,
  input  mux_mode_e                mode_i,
  input  logic [NUM_FP-1:0]        row_i,
  input  logic [NUM_FP-1:0]        fp_en_i,
  output logic [BP_MAX*LVL_W-1:0]  bp_lvl_o,
  output logic [NUM_FP*LVL_W-1:0]  fp_lvl_o
);

  logic                    run_d;
  logic                    pol_d;
  logic [PH_W-1:0]         ph_d;
  mux_mode_e               mode_d;
  logic [LVL_W-1:0]        top;
  logic [LVL_W-1:0]        off_lvl;
  logic [DUTY_W-1:0]       duty;
  logic [BP_MAX*LVL_W-1:0] bp_nxt;
  logic [NUM_FP*LVL_W-1:0] fp_nxt;

  // align control with the registered store read
  always_ff @(posedge clk) begin
    if (rst) begin
      run_d  <= 1'b0;
      pol_d  <= 1'b0;
      ph_d   <= '0;
      mode_d <= MODE_STATIC;
    end else begin
      run_d  <= run_i;
      pol_d  <= pol_i;
      ph_d   <= phase_i;
      mode_d <= mode_i;
    end
  end

  always_comb begin
    top     = top_of(mode_d);
    duty    = duty_of(mode_d);
    off_lvl = (top == LVL_W'(3)) ? LVL_W'(2) : top;
  end

  for (genvar j = 0; j < BP_MAX; j++) begin : g_bp
    assign bp_nxt[j*LVL_W +: LVL_W] =
      (!run_d || DUTY_W'(j) >= duty) ? '0 :
      mirror((PH_W'(j) == ph_d) ? top : LVL_W'(1), top, pol_d);
  end

  for (genvar i = 0; i < NUM_FP; i++) begin : g_fp
    assign fp_nxt[i*LVL_W +: LVL_W] =
      (!run_d || !fp_en_i[i]) ? '0 :
      mirror(row_i[i] ? LVL_W'(0) : off_lvl, top, pol_d);

    p_fp_gate_r6: assert property (@(posedge clk) disable iff (rst)
      !fp_en_i[i] |=> (fp_lvl_o[i*LVL_W +: LVL_W] == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_lvl_o <= '0;
      fp_lvl_o <= '0;
    end else begin
      bp_lvl_o <= bp_nxt;
      fp_lvl_o <= fp_nxt;
    end
  end

  p_quiet_off_r7: assert property (@(posedge clk) disable iff (rst)
    !run_d |=> (bp_lvl_o == '0 && fp_lvl_o == '0));

endmodule

// File: rtl/segmux_lcd.sv
module segmux_lcd
  import segmux_pkg::*;
#(
  parameter int NUM_FP        = 40,
  parameter int DIV_BASE_LOG2 = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lcd_en_i,
  input  logic [2:0]              mode_i,
  input  logic [1:0]              clk_div_i,
  input  logic [NUM_FP-1:0]       fp_en_i,
  input  logic                    host_we_i,
  input  logic [1:0]              host_addr_i,
  input  logic [NUM_FP-1:0]       host_wdata_i,
  output logic [NUM_FP-1:0]       host_rdata_o,
  output logic [7:0]              bp_lvl_o,
  output logic [2*NUM_FP-1:0]     fp_lvl_o
);

  logic [PH_W-1:0]   phase;
  logic              pol;
  mux_mode_e         mode_cur;
  logic [NUM_FP-1:0] disp_row;

  segmux_timing #(.DIV_BASE_LOG2(DIV_BASE_LOG2)) u_timing (
    .clk       (clk),
    .rst       (rst),
    .run_i     (lcd_en_i),
    .mode_i    (mode_i),
    .div_sel_i (clk_div_i),
    .phase_o   (phase),
    .pol_o     (pol),
    .mode_o    (mode_cur)
  );

  segmux_store #(.NUM_FP(NUM_FP)) u_store (
    .clk        (clk),
    .we_i       (host_we_i),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .rdata_o    (host_rdata_o),
    .disp_idx_i (phase),
    .disp_row_o (disp_row)
  );

  segmux_levels #(.NUM_FP(NUM_FP)) u_levels (
    .clk      (clk),
    .rst      (rst),
    .run_i    (lcd_en_i),
    .phase_i  (phase),
    .pol_i    (pol),
    .mode_i   (mode_cur),
    .row_i    (disp_row),
    .fp_en_i  (fp_en_i),
    .bp_lvl_o (bp_lvl_o),
    .fp_lvl_o (fp_lvl_o)
  );

endmodule

// File: tb/segmux_lcd_tb.sv
module segmux_lcd_tb;

  localparam int NFP  = 40;
  localparam int BASE = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           lcd_en = 1'b0;
  logic [2:0]     mode = 3'd0;
  logic [1:0]     cdiv = 2'd0;
  logic [NFP-1:0] fp_en = '0;
  logic           we = 1'b0;
  logic [1:0]     addr = 2'd0;
  logic [NFP-1:0] wdata = '0;
  logic [NFP-1:0] rdata;
  logic [7:0]     bp_lvl;
  logic [2*NFP-1:0] fp_lvl;

  logic [NFP-1:0] rows_m [4];
  int n_chk  = 0;
  int n_fail = 0;

  segmux_lcd #(.NUM_FP(NFP), .DIV_BASE_LOG2(BASE)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .lcd_en_i     (lcd_en),
    .mode_i       (mode),
    .clk_div_i    (cdiv),
    .fp_en_i      (fp_en),
    .host_we_i    (we),
    .host_addr_i  (addr),
    .host_wdata_i (wdata),
    .host_rdata_o (rdata),
    .bp_lvl_o     (bp_lvl),
    .fp_lvl_o     (fp_lvl)
  );

  always #2ns clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int b_norm(input int m);
    return (m > 4) ? 0 : m;
  endfunction

  function automatic int b_duty(input int m);
    case (m)
      0:       return 1;
      1, 2:    return 2;
      3:       return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int b_top(input int m);
    case (m)
      0:       return 1;
      1:       return 2;
      default: return 3;
    endcase
  endfunction

  task automatic build_exp(input int m, input int ph, input int pol,
                           output logic [7:0] eb, output logic [2*NFP-1:0] ef);
    int t;
    int d;
    int v;
    t = b_top(m);
    d = b_duty(m);
    for (int j = 0; j < 4; j++) begin
      if (j >= d) v = 0;
      else begin
        v = (j == ph) ? t : 1;
        if (pol != 0) v = t - v;
      end
      eb[2*j +: 2] = 2'(v);
    end
    for (int i = 0; i < NFP; i++) begin
      if (!fp_en[i]) v = 0;
      else begin
        v = rows_m[ph][i] ? 0 : ((t == 3) ? 2 : t);
        if (pol != 0) v = t - v;
      end
      ef[2*i +: 2] = 2'(v);
    end
  endtask

  task automatic host_write(input int a, input logic [NFP-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = 2'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
    rows_m[a] = d;
  endtask

  task automatic host_read_chk(input int a, input string req);
    @(negedge clk);
    addr = 2'(a);
    @(negedge clk);
    chk(rdata == rows_m[a], req, $sformatf("row %0d readback", a),
        128'(rdata), 128'(rows_m[a]));
  endtask

  // Runs the display from a fresh enable and checks every phase step.
  task automatic run_seq(input int m0, input int sel, input int nsteps,
                         input int sw_step, input int m1, input string req);
    int p;
    int ecnt;
    int ph;
    int pol;
    int cur;
    int pend;
    logic [7:0]       eb;
    logic [2*NFP-1:0] ef;
    p = 1 << (BASE + sel);
    @(negedge clk);
    mode = 3'(m0); cdiv = 2'(sel);
    @(negedge clk);
    lcd_en = 1'b1;
    ecnt = 0; ph = 0; pol = 0;
    cur = b_norm(m0); pend = cur;
    for (int s = 0; s < nsteps; s++) begin
      while (ecnt < p*s + 2 + p/2) begin
        @(posedge clk);
        ecnt++;
      end
      @(negedge clk);
      build_exp(cur, ph, pol, eb, ef);
      chk(bp_lvl == eb, req, $sformatf("mode %0d step %0d backplanes", m0, s),
          128'(bp_lvl), 128'(eb));
      chk(fp_lvl == ef, req, $sformatf("mode %0d step %0d frontplanes", m0, s),
          128'(fp_lvl), 128'(ef));
      if (s == sw_step) begin
        mode = 3'(m1);
        pend = b_norm(m1);
      end
      if (ph == b_duty(cur) - 1) begin
        ph = 0; pol = 1 - pol; cur = pend;
      end else begin
        ph++;
      end
    end
    @(negedge clk);
    lcd_en = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(bp_lvl == '0, "R10", "backplanes after reset", 128'(bp_lvl), 128'(0));
    chk(fp_lvl == '0, "R10", "frontplanes after reset", 128'(fp_lvl), 128'(0));
  endtask

  task automatic t_store;
    logic [NFP-1:0] mask;
    mask = ~(NFP'(1) << 5);
    host_write(0, 40'hA5_5A0F_F0C3 & mask);
    host_write(1, 40'h3C_C396_6901 & mask);
    host_write(2, 40'h0F_F00F_F0FF & mask);
    host_write(3, 40'hE1_1E87_7812 & mask);
    for (int a = 0; a < 4; a++) host_read_chk(a, "R9");
    @(negedge clk); lcd_en = 1'b1;
    repeat (5) @(negedge clk);
    lcd_en = 1'b0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) host_read_chk(a, "R9 after enable toggle");
  endtask

  task automatic t_modes;
    fp_en = 40'h7F_FFFF_FFDF;
    for (int m = 0; m < 6; m++)
      run_seq(m, 0, 2*b_duty(b_norm(m)) + 1, -1, 0, "R1/R3/R4/R5");
  endtask

  task automatic t_divider;
    run_seq(3, 1, 7, -1, 0, "R2");
    run_seq(1, 2, 5, -1, 0, "R2");
  endtask

  task automatic t_mode_switch;
    run_seq(4, 0, 10, 1, 2, "R8");
    run_seq(2, 0, 7, 2, 3, "R8");
  endtask

  task automatic t_fp_gate;
    @(negedge clk);
    fp_en = '0;
    mode = 3'd4; cdiv = 2'd0;
    @(negedge clk);
    lcd_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fp_lvl[11:10] == 2'd0, "R6", "fp5 with own enable clear",
        128'(fp_lvl[11:10]), 128'(0));
    fp_en[5] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(fp_lvl[11:10] == 2'd2, "R6", "fp5 one clock after enable",
        128'(fp_lvl[11:10]), 128'(2));
    lcd_en = 1'b0;
    fp_en = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fp_lvl == '0, "R6", "frontplanes with global enable clear",
        128'(fp_lvl), 128'(0));
  endtask

  task automatic t_disable;
    fp_en = 40'h7F_FFFF_FFDF;
    run_seq(4, 0, 3, -1, 0, "R7");
    @(negedge clk);
    chk(bp_lvl == '0 && fp_lvl == '0, "R7", "outputs after disable",
        128'({bp_lvl, fp_lvl}), 128'(0));
    run_seq(4, 0, 5, -1, 0, "R7 restart");
  endtask

  initial begin
    #(4ns * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_store();
    t_modes();
    t_divider();
    t_mode_switch();
    t_fp_gate();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule